// File: doc/BRIEF.md
# Processor Cluster Control Register Block

This block is the software-visible control and status register file for a cluster of up to four processor cores. It sits on a plain 32-bit register bus with a one-cycle write strobe and a registered read path. Through it software sets each core's 64-bit boot address, controls one interrupt group (status, mask, and separate write-only aliases that unmask and mask), holds fixed-reset configuration and cache-coherency control words, and asks individual cores to power down.

Each core's power-down request drives that core's power status output. It is also combined with the core's wait-for-interrupt level to form a handshake toward the power management unit. The handshake is asserted only when software has asked a core to power down and that core is idling. A separate read-only register reports the power state that the power management unit sends back.

Top module: `cluster_ctrl_regs`

## Requirements
- R1: A write takes effect at the clock edge where `wr_en` is high. `rdata` loads at the edge where `rd_en` is high and holds its value at other edges. Any access whose `addr[1:0]` is not zero is ignored on write and returns 0 on read.
- R2: The general registers are fully read/write over 32 bits and reset to these values: error control (0x00) to 0, configuration A (0x20) to 0x00000F0F, configuration B (0x24) to 0, coherency control (0x60) to 0x000F000F, snoop control (0x80) to 0.
- R3: Status register (0x10), bit i for i < IRQ_W:
  - It sets at any edge where `irq_evt[i]` is high.
  - Writing 1 to it clears it. Writing 0 leaves it unchanged.
  - When a set and a clear happen in the same cycle, the set wins.
  - Bits at or above IRQ_W read as 0.
- R4: The mask register (0x14) resets with all IRQ_W bits set, so every source starts masked. Bus writes to 0x14 do not change it.
- R5: A write to 0x18 clears the mask bits that are set in `wdata`. A write to 0x1C sets them. Neither address stores a value, and both read as 0.
- R6: `irq` is high exactly when some status bit is set and its mask bit is clear. It reflects register state from the edge just past.
- R7: Core i's boot address is split into a low half at 0x40+8i (reset 0xFFFF0000) and a high half at 0x44+8i (reset 0). `rvec[64i+63:64i]` carries {high, low}.
- R8: Power control (0x90) bits NUM_CORES-1:0 are the per-core power-down requests. The upper bits read as 0. `pwr_status` equals the request bits from the edge after the write.
- R9: `wfi_hs[i]` is request bit i ANDed with `wfi_in[i]` as captured at the previous edge. Reset clears both the requests and the captured levels.
- R10: Power status (0x94) is read-only. Bits NUM_CORES-1:0 return `pwr_state_in` at the read edge, other bits return 0, and writes are ignored.
- R11: Aligned offsets that are not mapped (for example 0x04, 0x28, 0x64, 0xFC) read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe, data returned the next cycle |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_evt | input | IRQ_W | Interrupt events that set status bits |
| wfi_in | input | NUM_CORES | Per-core wait-for-interrupt levels |
| pwr_state_in | input | NUM_CORES | Per-core power state from the power manager |
| irq | output | 1 | Combined unmasked interrupt |
| rvec | output | 64*NUM_CORES | Per-core boot addresses |
| pwr_status | output | NUM_CORES | Per-core power-down request level |
| wfi_hs | output | NUM_CORES | Per-core power-down handshake |

## Verification
The bench builds the block with its defaults: four cores, one interrupt source, an 8-bit address and the registered wait-for-interrupt capture. With four cores the whole boot-address window is in use, so the bench can show that it ends exactly where the coherency register begins. Sweeping all 64 word offsets reaches every unmapped hole. With a single interrupt bit, the same-cycle set-versus-clear race and the masking of the output can each be forced one cycle at a time.

// File: rtl/cc_regs_pkg.sv
package cc_regs_pkg;
   localparam int unsigned DW = 32;

   localparam logic [7:0] OFS_ERR    = 8'h00;
   localparam logic [7:0] OFS_STAT   = 8'h10;
   localparam logic [7:0] OFS_MASK   = 8'h14;
   localparam logic [7:0] OFS_UNMASK = 8'h18;
   localparam logic [7:0] OFS_SETMSK = 8'h1C;
   localparam logic [7:0] OFS_CFGA   = 8'h20;
   localparam logic [7:0] OFS_CFGB   = 8'h24;
   localparam logic [7:0] OFS_RVEC   = 8'h40;
   localparam logic [7:0] OFS_COH    = 8'h60;
   localparam logic [7:0] OFS_SNOOP  = 8'h80;
   localparam logic [7:0] OFS_PDREQ  = 8'h90;
   localparam logic [7:0] OFS_PSTAT  = 8'h94;

   localparam logic [DW-1:0] RST_CFGA   = 32'h0000_0F0F;
   localparam logic [DW-1:0] RST_COH    = 32'h000F_000F;
   localparam logic [DW-1:0] RST_RVEC_L = 32'hFFFF_0000;
   localparam logic [DW-1:0] RST_RVEC_H = 32'h0000_0000;

   typedef enum logic [2:0] {
      GEN_ERR, GEN_CFGA, GEN_CFGB, GEN_COH, GEN_SNOOP
   } gen_reg_e;
   localparam int unsigned NUM_GEN = 5;
endpackage

// File: rtl/cc_irq_unit.sv
module cc_irq_unit #(
   parameter int unsigned IRQ_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] evt,
   input  logic [IRQ_W-1:0] stat_clr,
   input  logic [IRQ_W-1:0] msk_clr,
   input  logic [IRQ_W-1:0] msk_set,
   output logic [IRQ_W-1:0] stat,
   output logic [IRQ_W-1:0] mask,
   output logic             irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         mask <= '1;
      end else begin
         stat <= (stat & ~stat_clr) | evt;
         mask <= (mask & ~msk_clr) | msk_set;
      end
   end

   assign irq = |(stat & ~mask);
endmodule

// File: rtl/cc_rvec_bank.sv
module cc_rvec_bank
   import cc_regs_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CORES-1:0]    we_lo,
   input  logic [NUM_CORES-1:0]    we_hi,
   input  logic [DW-1:0]           wdata,
   output logic [NUM_CORES*64-1:0] vec
);
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [DW-1:0] lo_q, hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= RST_RVEC_L;
            hi_q <= RST_RVEC_H;
         end else begin
            if (we_lo[c]) lo_q <= wdata;
            if (we_hi[c]) hi_q <= wdata;
         end
      end
      assign vec[c*64 +: 64] = {hi_q, lo_q};
   end
endmodule

// File: rtl/cc_pwr_unit.sv
module cc_pwr_unit #(
   parameter int unsigned NUM_CORES = 4,
   parameter bit          WFI_SYNC  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [NUM_CORES-1:0] wbits,
   input  logic [NUM_CORES-1:0] wfi_in,
   output logic [NUM_CORES-1:0] pd_req,
   output logic [NUM_CORES-1:0] wfi_hs
);
   logic [NUM_CORES-1:0] wfi_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pd_req <= '0;
      else if (we) pd_req <= wbits;
   end

   if (WFI_SYNC) begin : g_wfi_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wfi_cap <= '0;
         else        wfi_cap <= wfi_in;
      end
   end else begin : g_wfi_direct
      assign wfi_cap = wfi_in;
   end

   assign wfi_hs = pd_req & wfi_cap;
endmodule

// File: rtl/cluster_ctrl_regs.sv
module cluster_ctrl_regs
   import cc_regs_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned IRQ_W     = 1,
   parameter int unsigned ADDR_W    = 8,
   parameter bit          WFI_SYNC  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [31:0]             wdata,
   output logic [31:0]             rdata,
   input  logic [IRQ_W-1:0]        irq_evt,
   input  logic [NUM_CORES-1:0]    wfi_in,
   input  logic [NUM_CORES-1:0]    pwr_state_in,
   output logic                    irq,
   output logic [NUM_CORES*64-1:0] rvec,
   output logic [NUM_CORES-1:0]    pwr_status,
   output logic [NUM_CORES-1:0]    wfi_hs
);
   localparam int unsigned RVEC_SPAN = 8 * NUM_CORES;

   if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
      $error("NUM_CORES must be 1..4 to fit the boot-address window");
   end
   if (IRQ_W < 1 || IRQ_W > DW) begin : g_bad_irq
      $error("IRQ_W must be 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the 256-byte map");
   end

   function automatic logic [ADDR_W-1:0] ofs(input int unsigned o);
      return ADDR_W'(o);
   endfunction

   logic aligned, wr_ok;
   assign aligned = (addr[1:0] == 2'b00);
   assign wr_ok   = wr_en && aligned;

   // general read/write words
   localparam logic [NUM_GEN*8-1:0]  GEN_OFS = {OFS_SNOOP, OFS_COH, OFS_CFGB, OFS_CFGA, OFS_ERR};
   localparam logic [NUM_GEN*DW-1:0] GEN_RST = {32'h0, RST_COH, 32'h0, RST_CFGA, 32'h0};

   logic [DW-1:0] gen_q [NUM_GEN];
   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            gen_q[g] <= GEN_RST[g*DW +: DW];
         else if (wr_ok && addr == ofs(GEN_OFS[g*8 +: 8]))
            gen_q[g] <= wdata;
      end
   end

   // interrupt group
   logic [IRQ_W-1:0] stat, mask, stat_clr, msk_clr, msk_set;
   assign stat_clr = (wr_ok && addr == ofs(OFS_STAT))   ? wdata[IRQ_W-1:0] : '0;
   assign msk_clr  = (wr_ok && addr == ofs(OFS_UNMASK)) ? wdata[IRQ_W-1:0] : '0;
   assign msk_set  = (wr_ok && addr == ofs(OFS_SETMSK)) ? wdata[IRQ_W-1:0] : '0;

   cc_irq_unit #(.IRQ_W(IRQ_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (irq_evt),
      .stat_clr (stat_clr),
      .msk_clr  (msk_clr),
      .msk_set  (msk_set),
      .stat     (stat),
      .mask     (mask),
      .irq      (irq)
   );

   // boot addresses
   logic [NUM_CORES-1:0] we_lo, we_hi;
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_rv_dec
      assign we_lo[c] = wr_ok && addr == ofs(OFS_RVEC + 8*c);
      assign we_hi[c] = wr_ok && addr == ofs(OFS_RVEC + 8*c + 4);
   end

   cc_rvec_bank #(.NUM_CORES(NUM_CORES)) u_rvec (
      .clk   (clk),
      .rst_n (rst_n),
      .we_lo (we_lo),
      .we_hi (we_hi),
      .wdata (wdata),
      .vec   (rvec)
   );

   // power control
   cc_pwr_unit #(.NUM_CORES(NUM_CORES), .WFI_SYNC(WFI_SYNC)) u_pwr (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_ok && addr == ofs(OFS_PDREQ)),
      .wbits  (wdata[NUM_CORES-1:0]),
      .wfi_in (wfi_in),
      .pd_req (pwr_status),
      .wfi_hs (wfi_hs)
   );

   // read path
   logic [DW-1:0] rd_val;
   always_comb begin
      rd_val = '0;
      if (aligned) begin
         for (int g = 0; g < NUM_GEN; g++)
            if (addr == ofs(GEN_OFS[g*8 +: 8])) rd_val = gen_q[g];
         if (addr == ofs(OFS_STAT))  rd_val[IRQ_W-1:0] = stat;
         if (addr == ofs(OFS_MASK))  rd_val[IRQ_W-1:0] = mask;
         if (addr == ofs(OFS_PDREQ)) rd_val[NUM_CORES-1:0] = pwr_status;
         if (addr == ofs(OFS_PSTAT)) rd_val[NUM_CORES-1:0] = pwr_state_in;
         for (int c = 0; c < NUM_CORES; c++) begin
            if (addr == ofs(OFS_RVEC + 8*c))     rd_val = rvec[c*64 +: 32];
            if (addr == ofs(OFS_RVEC + 8*c + 4)) rd_val = rvec[c*64+32 +: 32];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end

   if (OFS_RVEC + RVEC_SPAN > OFS_COH) begin : g_bad_span
      $error("boot-address window overlaps coherency control");
   end
endmodule

// File: rtl/cc_regs_chk.sv
module cc_regs_chk #(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned IRQ_W     = 1,
   parameter int unsigned ADDR_W    = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic                    rd_en,
   input logic [ADDR_W-1:0]       addr,
   input logic [31:0]             wdata,
   input logic [31:0]             rdata,
   input logic                    irq,
   input logic [NUM_CORES*64-1:0] rvec,
   input logic [NUM_CORES-1:0]    pwr_status,
   input logic [NUM_CORES-1:0]    wfi_hs
);
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));                                          // R1

   AST_SETMASK_QUIETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(8'h1C) && (&wdata[IRQ_W-1:0])) |=> !irq);    // R5

   AST_UNMASK_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(8'h18)) |=> (rdata == 32'h0));              // R5

   AST_RVEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rvec));                                           // R7

   AST_PDREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(8'h90)) |=> $stable(pwr_status));          // R8

   AST_HS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wfi_hs & ~pwr_status) == '0);                                       // R9

   AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(8'h04)) |=> (rdata == 32'h0));              // R11
endmodule

bind cluster_ctrl_regs cc_regs_chk #(
   .NUM_CORES(NUM_CORES), .IRQ_W(IRQ_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .irq(irq), .rvec(rvec),
   .pwr_status(pwr_status), .wfi_hs(wfi_hs)
);

// File: tb/cluster_ctrl_regs_bench.sv
`timescale 1ns/1ps
module cluster_ctrl_regs_bench;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [0:0]    irq_evt = '0;
   logic [NC-1:0] wfi_in = '0, pwr_state_in = '0;
   logic          irq;
   logic [NC*64-1:0] rvec;
   logic [NC-1:0] pwr_status, wfi_hs;

   always #10 clk = ~clk;

   cluster_ctrl_regs u_cluster_ctrl_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_evt(irq_evt), .wfi_in(wfi_in),
      .pwr_state_in(pwr_state_in), .irq(irq), .rvec(rvec),
      .pwr_status(pwr_status), .wfi_hs(wfi_hs)
   );

   int tests = 0, fails = 0, cycles = 0;
   bit done = 0;

   // behavioural reference model
   logic [31:0] m_word [64];
   logic        m_stat, m_mask;
   logic [NC-1:0] m_pd, m_wfi;
   logic [31:0] m_rdata;
   string       rd_tag = "R1";

   function automatic string tag_of(input logic [7:0] a);
      if (a[1:0] != 0) return "R1";
      case (a)
         8'h00, 8'h20, 8'h24, 8'h60, 8'h80: return "R2";
         8'h10: return "R3";
         8'h14: return "R4";
         8'h18, 8'h1C: return "R5";
         8'h90: return "R8";
         8'h94: return "R10";
         default: return (a >= 8'h40 && a < 8'h60) ? "R7" : "R11";
      endcase
   endfunction

   function automatic logic [31:0] model_read(input logic [7:0] a);
      if (a[1:0] != 0) return 0;
      case (a)
         8'h00, 8'h20, 8'h24, 8'h60, 8'h80: return m_word[a>>2];
         8'h10: return {31'b0, m_stat};
         8'h14: return {31'b0, m_mask};
         8'h90: return {28'b0, m_pd};
         8'h94: return {28'b0, pwr_state_in};
         default: return (a >= 8'h40 && a < 8'h60) ? m_word[a>>2] : 32'h0;
      endcase
   endfunction

   task automatic model_reset();
      foreach (m_word[i]) m_word[i] = 32'h0;
      m_word[8'h20>>2] = 32'h0000_0F0F;
      m_word[8'h60>>2] = 32'h000F_000F;
      for (int c = 0; c < NC; c++) m_word[(8'h40>>2) + 2*c] = 32'hFFFF_0000;
      m_stat = 0; m_mask = 1; m_pd = '0; m_wfi = '0; m_rdata = '0;
   endtask

   task automatic check(input string tag, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else begin
         logic clr;
         if (rd_en) begin m_rdata = model_read(addr); rd_tag = tag_of(addr); end
         clr = 0;
         if (wr_en && addr[1:0] == 0) begin
            case (addr)
               8'h00, 8'h20, 8'h24, 8'h60, 8'h80: m_word[addr>>2] = wdata;
               8'h10: clr = wdata[0];
               8'h18: if (wdata[0]) m_mask = 0;
               8'h1C: if (wdata[0]) m_mask = 1;
               8'h90: m_pd = wdata[NC-1:0];
               default: if (addr >= 8'h40 && addr < 8'h60) m_word[addr>>2] = wdata;
            endcase
         end
         m_stat = (m_stat & ~clr) | irq_evt[0];
         m_wfi = wfi_in;
      end
   end

   // compare away from the edge, every clock
   always @(posedge clk) begin
      #5;
      if (!done) begin
         logic [NC*64-1:0] ev;
         for (int c = 0; c < NC; c++)
            ev[c*64 +: 64] = {m_word[(8'h44>>2) + 2*c], m_word[(8'h40>>2) + 2*c]};
         check("R6", "irq", 256'(irq), 256'(m_stat & ~m_mask));
         check("R7", "rvec", 256'(rvec), 256'(ev));
         check("R8", "pwr_status", 256'(pwr_status), 256'(m_pd));
         check("R9", "wfi_hs", 256'(wfi_hs), 256'(m_pd & m_wfi));
         check(rd_tag, "rdata", 256'(rdata), 256'(m_rdata));
      end
   end

   task automatic idle();
      @(negedge clk);
      wr_en = 0; rd_en = 0; irq_evt = 0;
   endtask
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; rd_en = 0; addr = a; wdata = d; irq_evt = 0;
   endtask
   task automatic rd(input logic [7:0] a);
      @(negedge clk);
      wr_en = 0; rd_en = 1; addr = a; irq_evt = 0;
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R2 R4 R7 R10 R11: reset values and holes across the whole map
      for (int i = 0; i < 64; i++) rd(8'(i*4));
      // R1 misaligned access ignored
      wr(8'h21, 32'hDEAD_BEEF); rd(8'h21); rd(8'h20);
      // R2 general words
      wr(8'h00, 32'h1234_5678); wr(8'h24, 32'hA5A5_5A5A); wr(8'h60, 32'h0);
      wr(8'h80, 32'hFFFF_FFFF); rd(8'h00); rd(8'h24); rd(8'h60); rd(8'h80);
      // R7 boot addresses, edge of window
      for (int c = 0; c < NC; c++) begin
         wr(8'(8'h40 + 8*c), 32'h1000_0000 * (c+1));
         wr(8'(8'h44 + 8*c), 32'hC000_0000 + c);
      end
      wr(8'h5C, 32'h7777_0000); rd(8'h5C); rd(8'h58);
      // R11 writes to holes
      wr(8'h04, 32'hFFFF_FFFF); wr(8'h28, 32'h1); wr(8'h64, 32'h2); wr(8'hFC, 32'h3);
      rd(8'h04); rd(8'h28); rd(8'h64); rd(8'hFC);
      // R3 R4 R5 R6 interrupt group
      @(negedge clk); wr_en = 0; rd_en = 0; irq_evt = 1;
      idle(); rd(8'h10);
      wr(8'h14, 32'h0); rd(8'h14);
      wr(8'h18, 32'h1); rd(8'h14); rd(8'h18);
      wr(8'h10, 32'h0); rd(8'h10);
      @(negedge clk); wr_en = 1; addr = 8'h10; wdata = 1; irq_evt = 1;
      idle(); rd(8'h10);
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
      @(negedge clk); wr_en = 0; irq_evt = 1;
      wr(8'h1C, 32'h1); rd(8'h1C); rd(8'h14);
      // R8 R9 R10 power control and handshake
      wr(8'h90, 32'hFFFF_FFF5); rd(8'h90);
      @(negedge clk); wr_en = 0; rd_en = 0; wfi_in = 4'hF;
      idle(); wfi_in = 4'h6; idle(); idle();
      wr(8'h90, 32'h0000_000A); wfi_in = 4'hA; idle(); idle();
      pwr_state_in = 4'h9; rd(8'h94);
      wr(8'h94, 32'hFFFF_FFFF); rd(8'h94); rd(8'h90);
      // mixed traffic
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         addr = 8'(($urandom % 40) * 4);
         if (addr > 8'h60) addr = (($urandom % 2) != 0) ? 8'h90 : 8'h94;
         wdata = $urandom;
         wr_en = ($urandom % 3) == 0;
         rd_en = ($urandom % 2) == 0;
         irq_evt = 1'(($urandom % 7) == 0);
         wfi_in = 4'($urandom);
         pwr_state_in = 4'($urandom);
      end
      idle();
      // reset mid-run: everything returns to reset values
      @(negedge clk); rst_n = 0; wfi_in = 4'hF;
      @(negedge clk); rst_n = 1;
      rd(8'h20); rd(8'h60); rd(8'h40); rd(8'h14); rd(8'h90);
      idle(); idle();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule